// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Controller

This block sits between a free-running source clock and one gated clock output. It exists for low-power operation. An active-low stop request may change at any time with no relation to the clock. The block passes the request through a synchronizer chain that runs on the source clock. It then switches the output on or off only while the source clock is low. As a result, a stopped output always rests low, and every high phase the output shows is a full source high phase.

Each time the output is released, a minimum-run counter is loaded. A stop request cannot take effect until that counter has drained. A stop request that arrives inside this window is remembered and honoured later, even if it has gone away by then. On and off latencies are fixed parameters counted in source rising edges. A `running` flag reports whether the output is currently passing pulses. Gating this output has no effect on any other clock in the system.

Top module: `clock_stop_ctrl`

## Requirements
- R1: After reset, `running` is 1, `clk_out` follows `clk_src`, and the minimum-run window is fully loaded. With the request held active through reset and afterwards, exactly MIN_RUN+OFF_LAT pulses appear after reset release.
- R2: `stop_req_n` is sampled through SYNC_STAGES flops on `clk_src`. A low level means "stop" and a high level means "run". The synchronizer resets to the run state.
- R3: Whenever `running` is 0, `clk_out` is held at 0.
- R4: Every high phase of `clk_out` lasts a full source high phase (5 ns at 100 MHz). The enable changes only while `clk_src` is low.
- R5: Off latency. With the minimum-run window drained, suppose the request goes low just after source rising edge E0. The last output pulse is then released on edge E0+SYNC_STAGES+OFF_LAT.
- R6: On latency. Suppose the output is stopped and the request goes high just after edge E0. The first output pulse is then released on edge E0+SYNC_STAGES+ON_LAT+1.
- R7: Each run releases at least MIN_RUN pulses. If the request is already active during the run's first pulses, the run contains exactly MIN_RUN+OFF_LAT pulses.
- R8: A stop request that is active for only a few cycles inside the minimum-run window is deferred, not dropped. The run still ends after MIN_RUN+OFF_LAT pulses. The output then restarts by itself, with a gap of ON_LAT missing pulses.
- R9: `running` is 1 during exactly the source periods in which a pulse is released, so `clk_out` equals `clk_src` AND `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| clk_out | output | 1 | Gated clock, parks low |
| running | output | 1 | High while the output passes pulses |

## Verification
Some properties are checked on every source edge:
- the gate enable is stable across each high phase;
- a stop happens only once the minimum-run counter is empty and a request, live or deferred, exists;
- a restart happens only with the request clear, and always reloads the counter;
- a deferred request survives until the output is stopped.

Other behaviour can only be shown by the bench's directed scenarios, which count edges and pulses: the exact on and off latencies through the synchronizer, the pulse count of each run, the gap after a deferred stop, and the full width of every released high phase.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic {
    PH_HALT = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // true on the final eligible edge of a latency window of lat edges
  function automatic logic last_step(input int unsigned cnt, input int unsigned lat);
    return (cnt + 1) >= lat;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic req_stop
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= async_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_n};
      end
    end
  endgenerate

  assign req_stop = ~chain[STAGES-1];

endmodule

// File: rtl/csc_sequencer.sv
module csc_sequencer
  import csc_pkg::*;
#(
  parameter int unsigned MIN_RUN = 10,
  parameter int unsigned ON_LAT  = 2,
  parameter int unsigned OFF_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_want,
  input  logic pulse_seen,
  output logic run_en
);

  localparam int unsigned CW = cnt_bits(MIN_RUN);
  localparam int unsigned LW = cnt_bits(max2(ON_LAT, OFF_LAT));
  localparam logic [CW-1:0] RUN_LOAD = CW'(MIN_RUN);

  phase_t          phase;
  logic [CW-1:0]   run_left;
  logic [LW-1:0]   lat_cnt;
  logic            stop_pend;

  logic            hold_off;
  logic            want_halt;
  logic            step;
  logic            fire;
  int unsigned     lat_lim;

  always_comb begin
    hold_off  = (run_left != '0);
    want_halt = stop_want | stop_pend;
    if (phase == PH_RUN) begin
      step    = want_halt & ~hold_off;
      lat_lim = OFF_LAT;
    end else begin
      step    = ~stop_want;
      lat_lim = ON_LAT;
    end
    fire = step & last_step(32'(lat_cnt), lat_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RUN;
      run_left  <= RUN_LOAD;
      lat_cnt   <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (phase == PH_RUN && pulse_seen && hold_off)
        run_left <= run_left - 1'b1;
      if (fire) begin
        lat_cnt   <= '0;
        stop_pend <= 1'b0;
        if (phase == PH_RUN) begin
          phase <= PH_HALT;
        end else begin
          phase    <= PH_RUN;
          run_left <= RUN_LOAD;
        end
      end else begin
        lat_cnt <= step ? lat_cnt + 1'b1 : '0;
        if (phase == PH_RUN && stop_want)
          stop_pend <= 1'b1;
      end
    end
  end

  assign run_en = (phase == PH_RUN);

  // R7: a stop only leaves the run state once the minimum-run window is empty
  a_r7_min_run_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> ($past(run_left) == '0));

  // R7: every restart reloads the full window
  a_r7_reload_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> (run_left == RUN_LOAD));

  // R8: a halt needs a live or a deferred request
  a_r8_halt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> $past(stop_want || stop_pend));

  // R8: a deferred request is kept until the output stops
  a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pend && run_en) |=> (stop_pend || !run_en));

  // R6: a restart never happens while the synchronized request is active
  a_r6_start_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> !$past(stop_want));

endmodule

// File: rtl/csc_gate.sv
module csc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_d,
  output logic clk_o,
  output logic en_q
);

  // enable is retimed on the falling edge so it only moves while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign clk_o = clk & en_q;

  // R4: at each rising edge the low-phase enable already matches the request
  // made at the previous rising edge, so it cannot change during a high phase
  a_r4_enable_settled: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == en_d);

endmodule

// File: rtl/clock_stop_ctrl.sv
module clock_stop_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_RUN     = 10,
  parameter int unsigned ON_LAT      = 2,
  parameter int unsigned OFF_LAT     = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic stop_req_n,
  output logic clk_out,
  output logic running
);

  logic stop_want;
  logic run_en;
  logic en_low;

  csc_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .async_n  (stop_req_n),
    .req_stop (stop_want)
  );

  csc_sequencer #(
    .MIN_RUN (MIN_RUN),
    .ON_LAT  (ON_LAT),
    .OFF_LAT (OFF_LAT)
  ) u_seq (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .stop_want  (stop_want),
    .pulse_seen (en_low),
    .run_en     (run_en)
  );

  csc_gate u_gate (
    .clk   (clk_src),
    .rst_n (rst_n),
    .en_d  (run_en),
    .clk_o (clk_out),
    .en_q  (en_low)
  );

  assign running = en_low;

endmodule

// File: tb/test_clock_stop_ctrl.sv
`timescale 1ns/1ps
module test_clock_stop_ctrl;

  localparam int SYNC = 2;
  localparam int MINR = 10;
  localparam int ONL  = 2;
  localparam int OFFL = 2;

  logic clk_src = 1'b0;
  logic rst_n   = 1'b0;
  logic stop_req_n = 1'b0;
  logic clk_out;
  logic running;

  int n_checks = 0;
  int n_fail   = 0;
  int out_edges = 0;
  int runt_err = 0;
  int park_err = 0;
  int follow_err = 0;
  bit done = 1'b0;
  time t_rise = 0;

  clock_stop_ctrl #(
    .SYNC_STAGES (SYNC),
    .MIN_RUN     (MINR),
    .ON_LAT      (ONL),
    .OFF_LAT     (OFFL)
  ) i_clock_stop_ctrl (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .stop_req_n (stop_req_n),
    .clk_out    (clk_out),
    .running    (running)
  );

  always #5 clk_src = ~clk_src;

  always @(posedge clk_out) begin
    out_edges++;
    t_rise = $time;
  end

  always @(negedge clk_out) begin
    if ($time - t_rise != 5) runt_err++;
  end

  always @(posedge clk_src) begin
    #1;
    if (!running && clk_out) park_err++;
    if (running && !clk_out) follow_err++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_src);
    #2;
  endtask

  // R1 R7: reset state and first run with request held active
  task automatic t_reset;
    int base;
    stop_req_n = 1'b0;
    rst_n = 1'b0;
    edges(4);
    rst_n = 1'b1;
    base = out_edges;
    chk("R1 running after reset", int'(running), 1);
    edges(30);
    chk("R1 R7 pulses in first run", out_edges - base, MINR + OFFL);
    chk("R9 running low after stop", int'(running), 0);
    chk("R3 parked low", int'(clk_out), 0);
  endtask

  // R2 R6 on latency, then R7 run length when stop returns early
  task automatic t_on_latency;
    int first_k;
    int base;
    first_k = 0;
    stop_req_n = 1'b1;
    base = out_edges;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk_src);
      #1;
      if (first_k == 0 && clk_out) first_k = k;
    end
    chk("R2 R6 first pulse edge", first_k, SYNC + ONL + 1);
    chk("R9 running at restart", int'(running), 1);
    stop_req_n = 1'b0;
    edges(30);
    chk("R7 pulses in restarted run", out_edges - base, MINR + OFFL);
  endtask

  // R5 off latency with window drained
  task automatic t_off_latency;
    int base;
    stop_req_n = 1'b1;
    edges(30);
    base = out_edges;
    stop_req_n = 1'b0;
    edges(10);
    chk("R5 pulses after request", out_edges - base, SYNC + OFFL);
    chk("R3 parked low after off", int'(clk_out), 0);
  endtask

  // R8 short request in the window is deferred
  task automatic t_deferred;
    int gap_at;
    int gap_len;
    bit resumed;
    gap_at = 0;
    gap_len = 0;
    resumed = 1'b0;
    @(posedge clk_src);
    #2;
    stop_req_n = 1'b1;
    repeat (4) @(posedge clk_src);
    for (int idx = 1; idx <= 30; idx++) begin
      @(posedge clk_src);
      #1;
      if (idx == 2) stop_req_n = 1'b0;
      if (idx == 5) stop_req_n = 1'b1;
      if (!clk_out && gap_at == 0) gap_at = idx;
      if (gap_at != 0 && !resumed) begin
        if (clk_out) resumed = 1'b1;
        else gap_len++;
      end
    end
    chk("R8 first missing pulse index", gap_at, MINR + OFFL + 1);
    chk("R8 gap length", gap_len, ONL);
    chk("R8 output resumed", int'(running), 1);
  endtask

  task automatic t_monitors;
    chk("R4 runt pulses", runt_err, 0);
    chk("R3 high while parked", park_err, 0);
    chk("R9 low while running", follow_err, 0);
  endtask

  initial begin
    t_reset();
    t_on_latency();
    t_off_latency();
    t_deferred();
    t_monitors();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule